// File: doc/BRIEF.md
# Register Bank with Crossbar Pipeline Stages and Write-Cycle Forwarding

This block is a register bank with two read ports and one write port. A multiplexer crossbar sits in front of it, and every pass through that crossbar costs one full clock cycle, whether the data is going out or coming back. An instruction has the form `dst = src_a + src_b`. Its operands are read and pass through the read crossbar in the issue cycle. A two-stage adder computes over the next two cycles. In the fourth cycle the result passes back through the write crossbar, and the bank takes the new value at the end of that cycle.

Because the crossbar costs a whole cycle, forwarding can help in only one case: a dependent instruction whose operand read falls in the same cycle as its producer's result write. In that cycle each read port compares its own address with the address being written. On a match, the port takes the result in place of the old bank contents. This removes exactly one cycle from a dependent chain.

A busy bit for each register holds back any instruction that would read, or overwrite, a register whose write is still on its way and not yet in its write cycle. The `issue_ready` output goes low while such an instruction is held.

Top module: `xrf_pipe`

## Requirements
- R1: After reset, register i holds the value i, zero-extended to the data width. `wr_valid` is low, and `issue_ready` is high for any instruction.
- R2: An accepted instruction (`issue_valid` and `issue_ready` both high at a rising edge) drives `wr_valid` = 1, `wr_addr` = dst and `wr_data` = value(src_a) + value(src_b) exactly 3 cycles after its issue cycle. Values are taken in program order.
- R3: The bank takes the written value at the end of the write cycle. An instruction issued one or more cycles after that write cycle reads the new value from the bank.
- R4: An instruction issued in the write cycle of a register it reads gets the result being written, not the old bank value. Each read port decides this on its own, including when both sources name the written register.
- R5: `issue_ready` is low while src_a or src_b names a register whose pending write has not yet reached its write cycle.
- R6: In a chain of two dependent adds with no other hazards, the second add is accepted 3 cycles after the first and its write appears 6 cycles after the first add's issue.
- R7: Instructions with no register overlap are accepted in consecutive cycles, one per cycle.
- R8: `issue_ready` is low while dst names a register whose pending write has not yet reached its write cycle. The instruction is accepted in that write cycle.
- R9: Addition is modulo 2^DW, and the carry out of the top bit is dropped.
- R10: An instruction that is offered but held, and any cycle with `issue_valid` low, causes no write and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_dst | input | AW | Destination register number |
| issue_src_a | input | AW | First source register number |
| issue_src_b | input | AW | Second source register number |
| issue_ready | output | 1 | The offered instruction is accepted at this edge when valid |
| wr_valid | output | 1 | A result is passing the write crossbar this cycle |
| wr_addr | output | AW | Register being written this cycle |
| wr_data | output | DW | Value being written this cycle |

## Verification
Two functions can fall in the same cycle: the result write of one instruction and the operand read of an instruction that depends on it. That cycle is where the forwarding path must take priority over the bank. Directed dependent pairs provoke it on one read port and on both ports at once. Random traffic over a small set of eight registers makes it happen often, alongside stalls and overwrites of pending registers. The bench judges each case three ways: by the acceptance cycle it predicts from its own pending-write table, by the written value it predicts from its own architectural register model, and by the exact write cycle.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  // Forwarding decision for one read port: take the write-crossbar value
  // when a write to the same register passes in this very cycle.
  function automatic bit fwd_take(input bit wb_v, input int unsigned wb_a,
                                  input int unsigned rd_a);
    return wb_v && (wb_a == rd_a);
  endfunction

  // Contents a register takes at reset.
  function automatic logic [63:0] boot_value(input int unsigned idx);
    return 64'(idx);
  endfunction

endpackage

// File: rtl/xrf_bank.sv
module xrf_bank #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);
  import xrf_pkg::*;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= DW'(boot_value(i));
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];

  // R3
  bank_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wa)] == $past(wd));

endmodule

// File: rtl/xrf_rd_xbar.sv
module xrf_rd_xbar #(
  parameter int NREG  = 64,
  parameter int DW    = 64,
  parameter int AW    = $clog2(NREG),
  parameter int NPORT = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issue_fire,
  input  logic [AW-1:0]             issue_dst,
  input  logic [NPORT-1:0][AW-1:0]  rd_addr,
  input  logic [NPORT-1:0][DW-1:0]  bank_data,
  input  logic                      wb_valid,
  input  logic [AW-1:0]             wb_dst,
  input  logic [DW-1:0]             wb_data,
  output logic [NPORT-1:0]          fwd_hit,
  output logic                      op_valid,
  output logic [AW-1:0]             op_dst,
  output logic [NPORT-1:0][DW-1:0]  op_data
);
  import xrf_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_dst   <= '0;
    end else begin
      op_valid <= issue_fire;
      if (issue_fire) op_dst <= issue_dst;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [DW-1:0] sel;

    assign fwd_hit[p] = fwd_take(wb_valid, 32'(wb_dst), 32'(rd_addr[p]));
    assign sel        = fwd_hit[p] ? wb_data : bank_data[p];

    always_ff @(posedge clk) begin
      if (rst)             op_data[p] <= '0;
      else if (issue_fire) op_data[p] <= sel;
    end

    // R4
    fwd_value_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_fire && fwd_hit[p]) |=> op_data[p] == $past(wb_data));
  end

endmodule

// File: rtl/xrf_add2.sv
module xrf_add2 #(
  parameter int DW = 64,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_dst,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          mid_valid,
  output logic [AW-1:0] mid_dst,
  output logic          out_valid,
  output logic [AW-1:0] out_dst,
  output logic [DW-1:0] out_data
);
  localparam int HALF = DW / 2;
  localparam int HI   = DW - HALF;

  function automatic logic [HALF:0] low_part(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    return {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]};
  endfunction

  function automatic logic [HI-1:0] high_part(input logic [HI-1:0] a,
                                              input logic [HI-1:0] b,
                                              input logic c);
    return a + b + HI'(c);
  endfunction

  logic [HALF:0]   lo_now;
  logic [HALF-1:0] m_lo;
  logic            m_c;
  logic [HI-1:0]   m_ahi, m_bhi;

  assign lo_now = low_part(in_a, in_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_valid <= 1'b0;
      mid_dst   <= '0;
      m_lo      <= '0;
      m_c       <= 1'b0;
      m_ahi     <= '0;
      m_bhi     <= '0;
    end else begin
      mid_valid <= in_valid;
      mid_dst   <= in_dst;
      m_lo      <= lo_now[HALF-1:0];
      m_c       <= lo_now[HALF];
      m_ahi     <= in_a[DW-1:HALF];
      m_bhi     <= in_b[DW-1:HALF];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dst   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= mid_valid;
      out_dst   <= mid_dst;
      out_data  <= {high_part(m_ahi, m_bhi, m_c), m_lo};
    end
  end

  // R9
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid, 2) |-> (out_valid && out_data == $past(in_a, 2) + $past(in_b, 2)));

endmodule

// File: rtl/xrf_score.sv
module xrf_score #(
  parameter int NREG = 64,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [AW-1:0] issue_dst,
  input  logic [AW-1:0] issue_src_a,
  input  logic [AW-1:0] issue_src_b,
  input  logic          wb_valid,
  input  logic [AW-1:0] wb_dst,
  output logic          issue_ready,
  output logic          issue_fire
);
  logic [NREG-1:0] busy;
  logic haz_a, haz_b, haz_d;

  function automatic logic blocked(input logic [NREG-1:0] bz, input logic [AW-1:0] r,
                                   input logic wv, input logic [AW-1:0] wr);
    return bz[r] && !(wv && wr == r);
  endfunction

  assign haz_a       = blocked(busy, issue_src_a, wb_valid, wb_dst);
  assign haz_b       = blocked(busy, issue_src_b, wb_valid, wb_dst);
  assign haz_d       = blocked(busy, issue_dst,   wb_valid, wb_dst);
  assign issue_ready = !(haz_a || haz_b || haz_d);
  assign issue_fire  = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else begin
      if (wb_valid)   busy[wb_dst]    <= 1'b0;
      if (issue_fire) busy[issue_dst] <= 1'b1;
    end
  end

  // R5
  wb_had_owner_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> busy[wb_dst]);

endmodule

// File: rtl/xrf_pipe.sv
module xrf_pipe #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [AW-1:0] issue_dst,
  input  logic [AW-1:0] issue_src_a,
  input  logic [AW-1:0] issue_src_b,
  output logic          issue_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int NPORT = 2;

  logic                     issue_fire;
  logic [DW-1:0]            rd_a, rd_b;
  logic [NPORT-1:0][AW-1:0] rd_addr;
  logic [NPORT-1:0][DW-1:0] bank_data;
  logic [NPORT-1:0]         fwd_hit;
  logic                     op_valid;
  logic [AW-1:0]            op_dst;
  logic [NPORT-1:0][DW-1:0] op_data;
  logic                     mid_valid;
  logic [AW-1:0]            mid_dst;
  logic                     wb_valid;
  logic [AW-1:0]            wb_dst;
  logic [DW-1:0]            wb_data;

  assign rd_addr   = {issue_src_b, issue_src_a};
  assign bank_data = {rd_b, rd_a};

  xrf_score #(.NREG(NREG), .AW(AW)) i_score (
    .clk, .rst, .issue_valid, .issue_dst, .issue_src_a, .issue_src_b,
    .wb_valid, .wb_dst, .issue_ready, .issue_fire
  );

  xrf_bank #(.NREG(NREG), .DW(DW), .AW(AW)) i_bank (
    .clk, .rst, .ra_a(issue_src_a), .ra_b(issue_src_b), .rd_a, .rd_b,
    .we(wb_valid), .wa(wb_dst), .wd(wb_data)
  );

  xrf_rd_xbar #(.NREG(NREG), .DW(DW), .AW(AW), .NPORT(NPORT)) i_rdx (
    .clk, .rst, .issue_fire, .issue_dst, .rd_addr, .bank_data,
    .wb_valid, .wb_dst, .wb_data, .fwd_hit, .op_valid, .op_dst, .op_data
  );

  xrf_add2 #(.DW(DW), .AW(AW)) i_add (
    .clk, .rst, .in_valid(op_valid), .in_dst(op_dst),
    .in_a(op_data[0]), .in_b(op_data[1]),
    .mid_valid, .mid_dst, .out_valid(wb_valid), .out_dst(wb_dst), .out_data(wb_data)
  );

  assign wr_valid = wb_valid;
  assign wr_addr  = wb_dst;
  assign wr_data  = wb_data;

  // R5
  no_early_read_chk: assert property (@(posedge clk) disable iff (rst)
    issue_fire |-> !(op_valid  && (op_dst  == issue_src_a || op_dst  == issue_src_b)) &&
                   !(mid_valid && (mid_dst == issue_src_a || mid_dst == issue_src_b)));

  // R8
  no_double_owner_chk: assert property (@(posedge clk) disable iff (rst)
    issue_fire |-> !(op_valid && op_dst == issue_dst) && !(mid_valid && mid_dst == issue_dst));

endmodule

// File: tb/test_xrf_pipe.sv
module test_xrf_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 64;
  localparam int DW   = 64;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0;
  logic [AW-1:0] issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
  logic issue_ready, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  xrf_pipe #(.NREG(NREG), .DW(DW), .AW(AW)) i_xrf_pipe (
    .clk, .rst, .issue_valid, .issue_dst, .issue_src_a, .issue_src_b,
    .issue_ready, .wr_valid, .wr_addr, .wr_data
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R2";
  logic [DW-1:0] arch [NREG];
  int            pend [NREG];
  bit            exp_v [8];
  logic [AW-1:0] exp_a [8];
  logic [DW-1:0] exp_d [8];

  function automatic logic [DW-1:0] ref_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  function automatic bit ref_ready(input logic [AW-1:0] d, input logic [AW-1:0] a,
                                   input logic [AW-1:0] b, input int now);
    return !(pend[a] > now || pend[b] > now || pend[d] > now);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input logic [AW-1:0] d, input logic [AW-1:0] a,
                      input logic [AW-1:0] b, output bit fired, output int at);
    int slot;
    bit er;
    @(negedge clk);
    slot = cyc % 8;
    if (exp_v[slot]) begin
      check(wr_valid && wr_addr == exp_a[slot] && wr_data == exp_d[slot],
            {cur_tag, " write value/cycle"}, wr_data, exp_d[slot]);
      exp_v[slot] = 0;
    end else begin
      check(!wr_valid, "R10 no write expected", {63'b0, wr_valid}, 0);
    end
    issue_valid = v; issue_dst = d; issue_src_a = a; issue_src_b = b;
    #1;
    er = ref_ready(d, a, b, cyc);
    check(issue_ready == er, "R5/R8 ready", {63'b0, issue_ready}, {63'b0, er});
    fired = v && issue_ready;
    at = cyc;
    if (fired) begin
      exp_v[(cyc + 3) % 8] = 1;
      exp_a[(cyc + 3) % 8] = d;
      exp_d[(cyc + 3) % 8] = ref_add(arch[a], arch[b]);
      arch[d] = ref_add(arch[a], arch[b]);
      pend[d] = cyc + 3;
    end
  endtask

  task automatic issue(input logic [AW-1:0] d, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, output int at);
    bit f;
    do step(1'b1, d, a, b, f, at); while (!f);
  endtask

  task automatic idle(input int n);
    bit f; int at;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, f, at);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3;
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) begin arch[i] = DW'(i); pend[i] = -1; end
    for (int i = 0; i < 8; i++) exp_v[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check(issue_ready == 1'b1, "R1 ready after reset", {63'b0, issue_ready}, 1);
    check(wr_valid == 1'b0, "R1 no write after reset", {63'b0, wr_valid}, 0);

    // R1 and R2: reset contents read through an add (3 + 4)
    cur_tag = "R1";
    issue(6'd10, 6'd3, 6'd4, t0);
    idle(4);
    check(arch[10] == 64'd7, "R1 model sum of reset values", arch[10], 7);

    // R6 and R4: dependent pair through one port
    cur_tag = "R6";
    issue(6'd5, 6'd1, 6'd2, t0);
    issue(6'd4, 6'd3, 6'd5, t1);
    check(t1 - t0 == 3, "R6 dependent accept distance", DW'(t1 - t0), 3);
    idle(4);

    // R4: both ports read the register being written
    cur_tag = "R4";
    issue(6'd11, 6'd1, 6'd1, t0);
    issue(6'd12, 6'd11, 6'd11, t1);
    check(t1 - t0 == 3, "R4 both-port forward accept", DW'(t1 - t0), 3);
    issue(6'd13, 6'd0, 6'd12, t2);
    check(t2 - t1 == 3, "R4 port b forward accept", DW'(t2 - t1), 3);
    idle(4);

    // R3: read after the write cycle comes from the bank
    cur_tag = "R3";
    issue(6'd20, 6'd2, 6'd3, t0);
    idle(3);
    issue(6'd21, 6'd20, 6'd0, t1);
    check(t1 - t0 == 4, "R3 late read accept", DW'(t1 - t0), 4);
    idle(4);

    // R7: independent back-to-back issue
    cur_tag = "R7";
    issue(6'd30, 6'd1, 6'd9, t0);
    for (int i = 1; i < 8; i++) begin
      issue(6'(30 + i), 6'(1 + i), 6'(9 + i), t1);
      check(t1 - t0 == i, "R7 one per cycle", DW'(t1 - t0), DW'(i));
    end
    idle(4);

    // R8: overwrite of a pending destination
    cur_tag = "R8";
    issue(6'd40, 6'd1, 6'd2, t0);
    issue(6'd40, 6'd3, 6'd4, t1);
    check(t1 - t0 == 3, "R8 overwrite accept", DW'(t1 - t0), 3);
    idle(4);

    // R9: doubling chain wraps past the top bit
    cur_tag = "R9";
    for (int i = 0; i < 70; i++) issue(6'd50, 6'd50, 6'd50, t3);
    idle(4);
    check(arch[50] == 64'd0, "R9 model wrap", arch[50], 0);

    // Random mix over a small register set
    cur_tag = "R2";
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] d, a, b;
      d = AW'($urandom_range(7)); a = AW'($urandom_range(7)); b = AW'($urandom_range(7));
      issue(d, a, b, t0);
      if ($urandom_range(3) == 0) idle($urandom_range(3));
    end
    cur_tag = "R10";
    idle(8);
    for (int i = 0; i < 8; i++)
      check(!exp_v[i], "R2 all writes seen", {63'b0, exp_v[i]}, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule